// File: doc/BRIEF.md
# Timebase Interval Timer

This block is a free-running binary timebase for a small controller. Its counter advances once every second cycle of the source clock. Software chooses one of four counter bits as the interval tap. Whenever counting carries out of that bit, a sticky overflow flag is set. An interrupt request is raised while that flag is set and the interrupt is enabled. Three fixed counter bits are also brought out as slow clocks for neighbouring peripherals: an analogue sampler, a tone generator and a watchdog.

The counter is cleared in three ways: by a register write, by the stop-mode request, and optionally by power-on reset. A single 8-bit control word holds the interrupt enable, the overflow flag, the clear control and the tap select. The same word is read back for status.

The pacing is built as a two-state phase machine, with states `PH_EVEN` and `PH_ODD`. It has three transitions:
- `PH_EVEN -> PH_ODD`: a hold edge.
- `PH_ODD -> PH_EVEN`: a count edge, on which the counter increments.
- Any state to `PH_EVEN` on a clear.

Top module: `tbt_interval_timer`

## Requirements
- R1: After reset or a clear, the counter holds on the first clock edge and increments on the second. It then keeps alternating between a hold edge and an increment edge. The tap outputs show counter bit 6 (analogue sampler), bit 11 (tone generator) and bit 19 (watchdog).
- R2: The control word is laid out as follows:
  - bit 7 is the interrupt enable;
  - bit 6 is the overflow flag;
  - bit 2 is the clear control, which always reads as 1;
  - bits 1:0 are the tap select;
  - bits 5, 4 and 3 read as 0.
- R3: A write with bit 2 equal to 0 clears the counter and the phase to zero at that clock edge.
- R4: On every clock edge at which `stop_req` is high, the counter and the phase are cleared.
- R5: Select codes 00, 01, 10 and 11 pick counter bits 12, 14, 16 and 19. The flag is set at the edge where an increment takes the selected bit from 1 to 0.
- R6: The flag stays set until a write with bit 6 equal to 0. Writing 1 to bit 6 leaves the flag unchanged. If an overflow and a flag-clearing write fall on the same edge, the flag ends up set.
- R7: `irq` is high exactly while both the flag and the interrupt enable are 1.
- R8: After reset the control word reads 8'h04 and the counter is zero.
- R9: A clear takes priority over counting. An edge that clears the counter never sets the flag, even if it would otherwise have carried out of the selected bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source oscillation clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stop_req | input | 1 | Stop-mode entry request; clears the counter while high |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_data | output | 8 | Control word read value |
| irq | output | 1 | Interval interrupt request |
| adc_tap | output | 1 | Counter bit 6 for the analogue sampler clock |
| buzzer_tap | output | 1 | Counter bit 11 for the tone generator |
| wdog_tap | output | 1 | Counter bit 19 for the watchdog clock |

## Verification
The assertions assume the following about the inputs:
- `stop_req`, `wr_en` and `wr_data` are synchronous to `clk`.
- They hold known values from the end of reset onward.
- The stop request and the write strobe are single-cycle or level signals that change only between edges.

The stimulus drives every input on the falling edge and releases reset between edges. Clearing writes are timed against the reference model's own count, so that they land exactly on a carry edge. This is how the clear-versus-carry and the clear-versus-overflow priority cases are reached without any look inside the design.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    // Phase of the divide-by-two pacing machine
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_t;

    // Control word bit positions
    localparam int CW_W      = 8;
    localparam int CW_IE     = 7;
    localparam int CW_FLAG   = 6;
    localparam int CW_CLR    = 2;
    localparam int CW_SEL_LO = 0;
    localparam int SEL_W     = 2;

    typedef struct packed {
        logic             irq_en;
        logic             ovf_flag;
        logic [SEL_W-1:0] tap_sel;
    } ctrl_t;

endpackage

// File: rtl/tbt_prescale.sv
module tbt_prescale
    import tbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic step
);

    phase_t phase_q;
    phase_t phase_d;

    // Next-state decode
    always_comb begin
        phase_d = phase_q;
        if (clr) begin
            phase_d = PH_EVEN;
        end else begin
            unique case (phase_q)
                PH_EVEN: phase_d = PH_ODD;
                PH_ODD:  phase_d = PH_EVEN;
                default: phase_d = PH_EVEN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_EVEN;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Output decode: count on the odd phase only
    always_comb begin
        unique case (phase_q)
            PH_EVEN: step = 1'b0;
            PH_ODD:  step = ~clr;
            default: step = 1'b0;
        endcase
    end

    // R1: without a clear the phase alternates every edge
    a_r1_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (phase_q != $past(phase_q)));

    // R3/R4: a clear returns the machine to the even phase
    a_r3_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase_q == PH_EVEN));

endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int CNT_W   = 20,
    parameter bit POR_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt + 1'b1;
        end
    end

    generate
        if (POR_CLR) begin : g_por_clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt_d;
                end
            end
        end else begin : g_por_keep
            always_ff @(posedge clk) begin
                cnt <= cnt_d;
            end
        end
    endgenerate

    // R1: a step edge increments by exactly one
    a_r1_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (cnt == $past(cnt) + 1'b1));

    // R1: no step and no clear means hold
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt));

    // R3/R4: clear zeroes the counter
    a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/tbt_tap_sel.sv
module tbt_tap_sel
    import tbt_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TAP0  = 12,
    parameter int TAP1  = 14,
    parameter int TAP2  = 16,
    parameter int TAP3  = 19
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf_evt
);

    localparam int IDX_W = $clog2(CNT_W);

    logic [IDX_W-1:0] tap_idx;
    logic             low_ones;

    always_comb begin
        unique case (sel)
            2'd0: tap_idx = IDX_W'(TAP0);
            2'd1: tap_idx = IDX_W'(TAP1);
            2'd2: tap_idx = IDX_W'(TAP2);
            2'd3: tap_idx = IDX_W'(TAP3);
            default: tap_idx = IDX_W'(TAP0);
        endcase
    end

    // Carry out of the selected bit: that bit and all below it are ones
    always_comb begin
        low_ones = 1'b1;
        for (int i = 0; i < CNT_W; i++) begin
            if (i <= int'(tap_idx)) begin
                low_ones = low_ones & cnt[i];
            end
        end
    end

    // step is already suppressed by any clear (R9)
    assign ovf_evt = step & low_ones;

endmodule

// File: rtl/tbt_ctrl_reg.sv
module tbt_ctrl_reg
    import tbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW_W-1:0]  wr_data,
    input  logic             ovf_evt,
    output ctrl_t            ctrl,
    output logic             clr_wr,
    output logic [CW_W-1:0]  rd_data
);

    ctrl_t ctrl_d;
    logic  flag_wr_clr;

    assign clr_wr      = wr_en & ~wr_data[CW_CLR];
    assign flag_wr_clr = wr_en & ~wr_data[CW_FLAG];

    always_comb begin
        ctrl_d = ctrl;
        if (wr_en) begin
            ctrl_d.irq_en  = wr_data[CW_IE];
            ctrl_d.tap_sel = wr_data[CW_SEL_LO +: SEL_W];
        end
        if (ovf_evt) begin
            ctrl_d.ovf_flag = 1'b1;
        end else if (flag_wr_clr) begin
            ctrl_d.ovf_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            ctrl <= ctrl_d;
        end
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[CW_IE]               = ctrl.irq_en;
        rd_data[CW_FLAG]             = ctrl.ovf_flag;
        rd_data[CW_CLR]              = 1'b1;
        rd_data[CW_SEL_LO +: SEL_W]  = ctrl.tap_sel;
    end

    // R5: an overflow sets the flag
    a_r5_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ctrl.ovf_flag);

    // R6: the flag is sticky without a clearing write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ovf_flag && !flag_wr_clr) |=> ctrl.ovf_flag);

    // R6: the flag only rises on an overflow
    a_r6_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.ovf_flag) |-> $past(ovf_evt));

endmodule

// File: rtl/tbt_interval_timer.sv
module tbt_interval_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter bit POR_CLR  = 1'b1,
    parameter int TAP0     = 12,
    parameter int TAP1     = 14,
    parameter int TAP2     = 16,
    parameter int TAP3     = 19,
    parameter int TAP_ADC  = 6,
    parameter int TAP_BUZ  = 11,
    parameter int TAP_WDOG = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       adc_tap,
    output logic       buzzer_tap,
    output logic       wdog_tap
);

    ctrl_t            ctrl;
    logic             clr_wr;
    logic             clr;
    logic             step;
    logic             ovf_evt;
    logic [CNT_W-1:0] cnt;

    assign clr = clr_wr | stop_req;

    tbt_prescale i_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (step)
    );

    tbt_counter #(
        .CNT_W   (CNT_W),
        .POR_CLR (POR_CLR)
    ) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (step),
        .cnt   (cnt)
    );

    tbt_tap_sel #(
        .CNT_W (CNT_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) i_tap_sel (
        .cnt     (cnt),
        .step    (step),
        .sel     (ctrl.tap_sel),
        .ovf_evt (ovf_evt)
    );

    tbt_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ovf_evt (ovf_evt),
        .ctrl    (ctrl),
        .clr_wr  (clr_wr),
        .rd_data (rd_data)
    );

    assign irq        = ctrl.ovf_flag & ctrl.irq_en;
    assign adc_tap    = cnt[TAP_ADC];
    assign buzzer_tap = cnt[TAP_BUZ];
    assign wdog_tap   = cnt[TAP_WDOG];

    // R5: after an overflow the lowest-order tap bit has fallen to zero
    a_r5_tap_bit_fell: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (cnt[TAP0] == 1'b0));

    // R9: a clearing edge never raises the flag
    a_r9_clear_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ctrl.ovf_flag) |=> !ctrl.ovf_flag);

    // R4: stop request leaves the counter at zero
    a_r4_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (cnt == '0));

endmodule

// File: tb/test_tbt_interval_timer.sv
module test_tbt_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq, adc_tap, buzzer_tap, wdog_tap;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Reference model state
    int m_cnt = 0;
    int m_phase = 0;
    bit m_flag = 0;
    bit m_ie = 0;
    int m_sel = 0;

    always #4 clk = ~clk;

    tbt_interval_timer i_tbt_interval_timer (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .adc_tap(adc_tap), .buzzer_tap(buzzer_tap), .wdog_tap(wdog_tap)
    );

    function automatic int tap_of(int s);
        case (s)
            0: return 12;
            1: return 14;
            2: return 16;
            default: return 19;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd();
        return {m_ie, m_flag, 3'b000, 1'b1, m_sel[1:0]};
    endfunction

    // Behavioural model, updated on the same edges as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_phase = 0; m_flag = 0; m_ie = 0; m_sel = 0;
        end else begin
            bit clr_now, step_now, evt;
            int mask;
            clr_now  = (wr_en && !wr_data[2]) || stop_req;
            step_now = (m_phase == 1) && !clr_now;
            mask     = (1 << (tap_of(m_sel) + 1)) - 1;
            evt      = step_now && ((m_cnt & mask) == mask);
            if (clr_now) begin
                m_cnt = 0; m_phase = 0;
            end else begin
                if (step_now) m_cnt = (m_cnt + 1) & 32'hFFFFF;
                m_phase = 1 - m_phase;
            end
            if (evt) m_flag = 1;
            else if (wr_en && !wr_data[6]) m_flag = 0;
            if (wr_en) begin
                m_ie  = wr_data[7];
                m_sel = int'(wr_data[1:0]);
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_data !== exp_rd()) begin
                errors++;
                $display("FAIL R2/R6 control word: actual %h expected %h", rd_data, exp_rd());
            end
            if (irq !== (m_flag & m_ie)) begin
                errors++;
                $display("FAIL R7 irq: actual %b expected %b", irq, m_flag & m_ie);
            end
            if ({adc_tap, buzzer_tap, wdog_tap} !== {m_cnt[6], m_cnt[11], m_cnt[19]}) begin
                errors++;
                $display("FAIL R1 taps: actual %b expected %b",
                         {adc_tap, buzzer_tap, wdog_tap}, {m_cnt[6], m_cnt[11], m_cnt[19]});
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_carry_edge();
        while (!(((m_cnt & 32'h1FFF) == 32'h1FFF) && m_phase == 1)) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset values (one hold edge has passed: counter still zero)
        check("R8 reset word", int'(rd_data), 8'h04);
        check("R8 reset taps", int'({adc_tap, buzzer_tap, wdog_tap}), 0);

        // R1: free run; bit 6 rises after 64 steps = 128 edges from reset
        repeat (126) @(negedge clk);
        check("R1 adc tap before 128 edges", int'(adc_tap), 0);
        @(negedge clk);
        check("R1 adc tap at 128 edges", int'(adc_tap), 1);

        // R5/R7: select 00, enable irq
        wr(8'h84);
        while (!m_flag) @(negedge clk);
        check("R5 flag on bit 12 overflow", int'(rd_data[6]), 1);
        check("R7 irq with enable", int'(irq), 1);

        // R6: writing 1 to the flag keeps it
        wr(8'hC4);
        check("R6 write 1 keeps flag", int'(rd_data[6]), 1);
        wr(8'h04);
        check("R6 write 0 clears flag", int'(rd_data[6]), 0);
        check("R7 irq low without flag", int'(irq), 0);

        // R3: clearing write
        repeat (200) @(negedge clk);
        wr(8'h00);
        check("R3 counter cleared", int'({adc_tap, buzzer_tap}), 0);
        check("R2 clear bit reads 1", int'(rd_data[2]), 1);

        // R4: stop request clears
        repeat (140) @(negedge clk);
        check("R4 adc tap set before stop", int'(adc_tap), 1);
        stop_req = 1'b1;
        repeat (5) @(negedge clk);
        check("R4 counter held at zero", int'(adc_tap), 0);
        stop_req = 1'b0;

        // R9: clear on the carry edge does not set the flag
        wait_carry_edge();
        wr(8'h00);
        check("R9 clear beats overflow", int'(rd_data[6]), 0);

        // R6: overflow wins over flag-clearing write on the same edge
        wait_carry_edge();
        wr(8'h04);
        check("R6 overflow beats flag clear", int'(rd_data[6]), 1);

        // R5: select 01 (bit 14), cleared start, flag cleared
        wr(8'h01);
        repeat (65530) @(negedge clk);
        check("R5 no flag before bit 14 carry", int'(rd_data[6]), 0);
        while (!m_flag) @(negedge clk);
        check("R5 flag on bit 14 overflow", int'(rd_data[6]), 1);
        check("R7 irq masked when disabled", int'(irq), 0);

        // R5: select 10 and 11 do not fire within a short window
        wr(8'h02);
        repeat (3000) @(negedge clk);
        check("R5 sel 10 no early flag", int'(rd_data[6]), 0);
        wr(8'h03);
        repeat (3000) @(negedge clk);
        check("R5 sel 11 no early flag", int'(rd_data[6]), 0);
        check("R2 select readback", int'(rd_data[1:0]), 3);

        finish_run();
    end

endmodule